// File: doc/BRIEF.md
# Decade Pulse Scaler with Inhibit Feedback

This block counts single-cycle pulses in decimal. It is one decade of a scaler, built from four one-bit stages with weights 1, 2, 4 and 8. The weight-1 stage toggles on every pulse. Its falling carry feeds a scale-of-five formed by the weight-2, weight-4 and weight-8 stages. The weight-8 stage does not toggle. The carry of the weight-4 stage sets it, and the carry of the weight-1 stage clears it.

Division by ten comes from an inhibit gate and not from a compare-to-nine. While the weight-8 stage holds 1, the weight-1 carry is blocked from the weight-2 stage. That same carry clears the weight-8 stage. So the tenth pulse returns every stage to 0 and emits one carry-out strobe.

The count leaves the block through an output register. That register is loaded with the next stage state, so it is isolated from the feedback path. The carry-out strobe has the same single-cycle form as the input, so a second instance can take it directly as its input pulse. The input and output are plain strobes with no back-pressure: a decade counts every pulse it is given. A synchronous zero input clears the count.

Top module: `decade_scaler`

## Requirements
- R1: After the asynchronous reset (`rst_ni` low), `bcd_o` reads 0 and `carry_o` is low.
- R2: Each cycle with `pulse_i` high and `zero_i` low advances the count by one, modulo ten. The new count appears on `bcd_o` in the cycle after the pulse.
- R3: `bcd_o` is 1-2-4-8 weighted (bit 0 weight 1, bit 3 weight 8) and never reads a value above 9.
- R4: `carry_o` is high for exactly one cycle, in the same cycle that `bcd_o` goes from 9 to 0 because of a pulse. At no other time is it high.
- R5: In a cycle with `pulse_i` low and `zero_i` low, the count holds and `carry_o` stays low.
- R6: When `zero_i` is high, the next `bcd_o` is 0 and `carry_o` is low, whatever the count was. A pulse in the same cycle is ignored, including a pulse at count 9.
- R7: Bit 3 of `bcd_o` rises only on the pulse that takes the count from 7 to 8.
- R8: Pulses in consecutive cycles are each counted, with no pulse lost across the 9-to-0 wrap.
- R9: Feeding `carry_o` of one instance into `pulse_i` of a second instance makes the second instance count tens, one cycle behind the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zero_i | input | 1 | Synchronous clear to zero; takes priority over pulse_i |
| pulse_i | input | 1 | Single-cycle count strobe |
| bcd_o | output | 4 | Registered BCD count, 1-2-4-8 weighted |
| carry_o | output | 1 | Single-cycle decade carry strobe |

## Verification
The bench builds the block with its default stage layout: three toggle stages plus one set/clear stage. That layout has only ten reachable states, so a long pulse stream visits every state and every transition many times. The stream mixes isolated pulses, back-to-back bursts and clears, and the clears land on every count from 0 to 9. A second instance chained on the carry brings the tens digit, and the two-decade wrap at 99, within reach.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned DIGIT_W       = 4;
  localparam int unsigned TOGGLE_STAGES = DIGIT_W - 1;
  localparam int unsigned GATE_INDEX    = 1;
  localparam int unsigned HOLD_INDEX    = DIGIT_W - 1;

  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/dsc_toggle_stage.sv
module dsc_toggle_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic step_i,
  output logic q_o,
  output logic q_next_o,
  output logic carry_o
);
  logic q_r;

  always_comb begin
    if (zero_i)      q_next_o = 1'b0;
    else if (step_i) q_next_o = ~q_r;
    else             q_next_o = q_r;
  end

  // Carry fires only when this stage falls from 1 to 0.
  assign carry_o = step_i & q_r & ~zero_i;
  assign q_o     = q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= 1'b0;
    else         q_r <= q_next_o;
  end
endmodule

// File: rtl/dsc_hold_stage.sv
module dsc_hold_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic q_next_o
);
  logic q_r;

  // A set and a clear can coincide only on the 7-to-8 step, where set must win.
  always_comb begin
    if (zero_i)     q_next_o = 1'b0;
    else if (set_i) q_next_o = 1'b1;
    else if (clr_i) q_next_o = 1'b0;
    else            q_next_o = q_r;
  end

  assign q_o = q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= 1'b0;
    else         q_r <= q_next_o;
  end
endmodule

// File: rtl/dsc_inhibit_gate.sv
module dsc_inhibit_gate (
  input  logic carry_i,
  input  logic block_i,
  output logic pass_o
);
  assign pass_o = carry_i & ~block_i;
endmodule

// File: rtl/dsc_out_reg.sv
module dsc_out_reg
  import dsc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  digit_t digit_d_i,
  input  logic   carry_d_i,
  output digit_t digit_o,
  output logic   carry_o
);
  digit_t digit_r;
  logic   carry_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      digit_r <= '0;
      carry_r <= 1'b0;
    end else begin
      digit_r <= digit_d_i;
      carry_r <= carry_d_i;
    end
  end

  assign digit_o = digit_r;
  assign carry_o = carry_r;
endmodule

// File: rtl/decade_scaler.sv
module decade_scaler
  import dsc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               zero_i,
  input  logic               pulse_i,
  output logic [DIGIT_W-1:0] bcd_o,
  output logic               carry_o
);
  logic [TOGGLE_STAGES-1:0] tog_q;
  logic [TOGGLE_STAGES-1:0] tog_next;
  logic [TOGGLE_STAGES-1:0] tog_carry;
  logic [TOGGLE_STAGES-1:0] tog_step;
  logic                     gated_carry;
  logic                     hold_q;
  logic                     hold_next;
  logic                     decade_carry;
  digit_t                   digit_next;

  // The inhibit gate sees the weight-8 state from before this pulse.
  dsc_inhibit_gate u_gate (
    .carry_i (tog_carry[0]),
    .block_i (hold_q),
    .pass_o  (gated_carry)
  );

  for (genvar i = 0; i < TOGGLE_STAGES; i++) begin : g_tog
    if (i == 0) begin : g_first
      assign tog_step[i] = pulse_i;
    end else if (i == GATE_INDEX) begin : g_gated
      assign tog_step[i] = gated_carry;
    end else begin : g_chain
      assign tog_step[i] = tog_carry[i-1];
    end

    dsc_toggle_stage u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .zero_i   (zero_i),
      .step_i   (tog_step[i]),
      .q_o      (tog_q[i]),
      .q_next_o (tog_next[i]),
      .carry_o  (tog_carry[i])
    );
  end

  dsc_hold_stage u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zero_i   (zero_i),
    .set_i    (tog_carry[TOGGLE_STAGES-1]),
    .clr_i    (tog_carry[0]),
    .q_o      (hold_q),
    .q_next_o (hold_next)
  );

  // Tenth pulse: the weight-1 carry is blocked and leaves the decade.
  assign decade_carry = tog_carry[0] & hold_q;
  assign digit_next   = {hold_next, tog_next};

  dsc_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .digit_d_i (digit_next),
    .carry_d_i (decade_carry),
    .digit_o   (bcd_o),
    .carry_o   (carry_o)
  );
endmodule

// File: rtl/decade_scaler_chk.sv
module decade_scaler_chk
  import dsc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               zero_i,
  input logic               pulse_i,
  input logic [DIGIT_W-1:0] bcd_o,
  input logic               carry_o
);
  p_max_nine_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_o <= 4'd9);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !zero_i) |=>
      (bcd_o == (($past(bcd_o) == 4'd9) ? 4'd0 : $past(bcd_o) + 4'd1)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !zero_i) |=> ($stable(bcd_o) && !carry_o));

  p_carry_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (bcd_o == 4'd0 && $past(bcd_o) == 4'd9 && $past(pulse_i)));

  p_zero_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (bcd_o == 4'd0 && !carry_o));

  p_eight_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcd_o[3]) |-> ($past(bcd_o) == 4'd7));

  p_carry_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);
endmodule

bind decade_scaler decade_scaler_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .zero_i  (zero_i),
  .pulse_i (pulse_i),
  .bcd_o   (bcd_o),
  .carry_o (carry_o)
);

// File: tb/decade_scaler_tb.sv
`timescale 1ns/1ps
module decade_scaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zero = 1'b0;
  logic       pulse = 1'b0;
  logic [3:0] ones_bcd, tens_bcd;
  logic       ones_carry, tens_carry;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  int exp_ones = 0;
  int exp_tens = 0;
  bit exp_carry = 1'b0;
  bit prev_carry = 1'b0;
  int wraps = 0;

  always #4 clk = ~clk;

  decade_scaler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .zero_i(zero), .pulse_i(pulse),
    .bcd_o(ones_bcd), .carry_o(ones_carry)
  );

  decade_scaler u_tens (
    .clk_i(clk), .rst_ni(rst_n), .zero_i(zero), .pulse_i(ones_carry),
    .bcd_o(tens_bcd), .carry_o(tens_carry)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, then check after the capturing edge.
  task automatic step(input bit p, input bit z, input string req);
    @(negedge clk);
    pulse = p;
    zero  = z;
    @(negedge clk);
    pulse = 1'b0;
    zero  = 1'b0;
    // The tens digit follows the carry seen in the previous step.
    if (z) exp_tens = 0;
    else if (prev_carry) exp_tens = (exp_tens + 1) % 10;
    exp_carry = 1'b0;
    if (z) exp_ones = 0;
    else if (p) begin
      exp_carry = (exp_ones == 9);
      exp_ones  = (exp_ones + 1) % 10;
    end
    if (exp_carry) wraps++;
    prev_carry = exp_carry;
    check(req, ones_bcd, exp_ones);
    check({req, " carry R4"}, ones_carry, exp_carry);
    check("R3 range", (ones_bcd <= 4'd9), 1);
    check("R9 tens", tens_bcd, exp_tens);
  endtask

  task automatic burst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pulse = 1'b1;
      @(negedge clk);
      exp_tens = prev_carry ? (exp_tens + 1) % 10 : exp_tens;
      exp_carry = (exp_ones == 9);
      exp_ones = (exp_ones + 1) % 10;
      prev_carry = exp_carry;
      check(req, ones_bcd, exp_ones);
      check("R8 carry R4", ones_carry, exp_carry);
      check("R9 tens", tens_bcd, exp_tens);
    end
    pulse = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset bcd", ones_bcd, 0);
    check("R1 reset carry", ones_carry, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", ones_bcd, 0);

    // R2/R7/R4: single pulses through two full decades
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, "R2 single");
    check("R4 two wraps", wraps, 2);
    // R7: walk to 7, then the next pulse sets bit 3
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R2 to seven");
    check("R7 bit3 low at 7", ones_bcd[3], 0);
    step(1'b1, 1'b0, "R7 eight");
    check("R7 bit3 set at 8", ones_bcd[3], 1);

    // R5: idle cycles hold the count
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R5 hold");

    // R6: clear from every count, with a coincident pulse
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < k; j++) step(1'b1, 1'b0, "R2 approach");
      step(1'b1, 1'b1, "R6 zero wins");
      check("R6 no carry", ones_carry, 0);
    end

    // R8: back-to-back pulses across many wraps
    burst(37, "R8 burst");
    step(1'b0, 1'b0, "R5 after burst");

    // Mixed pattern driven by an LFSR, long enough to reach the 99 wrap
    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 1500; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(lf[0] | lf[1], (lf == 8'h17), "R2 mixed");
      end
    end
    burst(120, "R8 long burst");
    step(1'b0, 1'b0, "R9 settle");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule